// File: doc/BRIEF.md
# Program/Erase Status Sequencer

This block runs the self-timed internal operations of a byte-wide flash array. A command decoder asks it to program one byte, erase one sector or erase the whole chip. Each wait is counted in clock cycles, and the length of each wait is a parameter. The block raises `busy` for the length of the operation. It drives write and erase strobes on a small array-access port. The storage cells themselves sit outside the block.

While an operation runs, a host read returns a status byte instead of array data. Bit 7 is the inverse of bit 7 of the byte being programmed, and it is 0 during any erase. Bit 6 inverts on every read. Bits 5 to 0 are 0. Once the operation ends, reads pass array data through again.

A chip erase has two phases. It first walks every address in ascending order, writing 00h and reading each byte back. It then erases the sectors one after another, from sector 0 upward.

States:
- `ST_IDLE`
- `ST_PROG_WAIT` and `ST_PROG_WRITE`
- `ST_SECT_WAIT` and `ST_SECT_PULSE`
- `ST_PRE_WRITE` and `ST_PRE_VERIFY`
- `ST_CHIP_WAIT` and `ST_CHIP_PULSE`

Transitions:
- Idle to a program, sector or pre-write state when a start is accepted.
- Each wait state to its write or pulse state when the timer expires.
- Pre-write to verify, then verify back to pre-write for the same or the next byte, or on to chip-wait after the last byte.
- Chip-pulse to chip-wait for the next sector, or to idle after the last sector.
- Program-write and sector-pulse to idle.

Top module: `flash_op_seq`

## Requirements
- R1: After reset, `busy` is 0, `arr_we` and `arr_erase` are 0, and the status toggle bit starts at 0.
- R2: A start is accepted only in idle, and only with `start_op` 01 (program), 10 (sector erase) or 11 (chip erase). `busy` rises in the cycle after acceptance. A start with code 00, or any start while busy, has no effect.
- R3: A byte program keeps `busy` high for PROG_CYC+1 cycles. In its last busy cycle it writes the byte once, at the latched address.
- R4: While busy, `host_rdata` is the status byte, and bits 5..0 are 0.
- R5: Status bit 7 is the inverse of bit 7 of the programming data during a program, and 0 during either erase. After completion, reads return the true array data.
- R6: Status bit 6 inverts after every `host_rd` while busy. It holds its value when idle.
- R7: A sector erase keeps `busy` high for SERASE_CYC+1 cycles. It issues a single erase pulse whose `arr_sector` is the top SECT_W bits of the latched address. Other sectors are untouched.
- R8: Chip erase first writes 00h to each address from 0 upward, one write followed by one verify read. A byte whose verify read is not 00h is written again before the walk moves on.
- R9: After the pre-program walk, chip erase issues one erase pulse per sector, in ascending sector order. Each pulse follows a CHIP_SECT_CYC-cycle wait.
- R10: Programming only clears bits: the written byte is the old byte ANDed with the requested data.
- R11: In idle, `arr_addr` follows `host_addr` and `host_rdata` equals `arr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation request |
| start_op | input | 2 | 01 program, 10 sector erase, 11 chip erase |
| start_addr | input | ADDR_W | Target byte or sector address |
| start_data | input | 8 | Byte to program |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host read address |
| host_rdata | output | 8 | Array data, or status while busy |
| busy | output | 1 | Operation in progress |
| arr_addr | output | ADDR_W | Array byte address |
| arr_rdata | input | 8 | Array read data for `arr_addr` |
| arr_we | output | 1 | Array byte write strobe |
| arr_wdata | output | 8 | Array write data |
| arr_erase | output | 1 | Sector erase strobe |
| arr_sector | output | SECT_W | Sector to erase |

## Verification
The bench builds the block with a 64-byte array split into four 16-byte sectors. The program wait is 4 cycles, the sector erase wait is 6 cycles, and the per-sector chip erase wait is 5 cycles. With these values a complete chip erase, including the whole pre-program walk and every sector pulse, finishes in about 150 cycles, so every address and every sector boundary can be observed. The bench's array model drops one pre-program write once, which forces the block down its rewrite path.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_SECT = 2'b10,
        OP_CHIP = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG_WAIT,
        ST_PROG_WRITE,
        ST_SECT_WAIT,
        ST_SECT_PULSE,
        ST_PRE_WRITE,
        ST_PRE_VERIFY,
        ST_CHIP_WAIT,
        ST_CHIP_PULSE
    } state_e;
endpackage

// File: rtl/op_timer.sv
module op_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/status_gen.sv
module status_gen
    import flash_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              rd,
    input  logic              prog_mode,
    input  logic              prog_bit7,
    output logic [BYTE_W-1:0] status
);
    logic tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tog_q <= 1'b0;
        else if (busy && rd)
            tog_q <= ~tog_q;
    end

    always_comb begin
        status    = '0;
        status[7] = prog_mode ? ~prog_bit7 : 1'b0;
        status[6] = tog_q;
    end

    assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd) |=> (tog_q != $past(tog_q)));
    assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |=> $stable(tog_q));
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int SECT_W        = 8,
    parameter int PROG_CYC      = 2000,
    parameter int SERASE_CYC    = 1000000,
    parameter int CHIP_SECT_CYC = 781250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        start_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [7:0]        host_rdata,
    output logic              busy,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_rdata,
    output logic              arr_we,
    output logic [7:0]        arr_wdata,
    output logic              arr_erase,
    output logic [SECT_W-1:0] arr_sector
);
    localparam int MAX_AB = (PROG_CYC > SERASE_CYC) ? PROG_CYC : SERASE_CYC;
    localparam int MAXC   = (MAX_AB > CHIP_SECT_CYC) ? MAX_AB : CHIP_SECT_CYC;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PROG_LD = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] SECT_LD = CW'(SERASE_CYC - 1);
    localparam logic [CW-1:0] CHIP_LD = CW'(CHIP_SECT_CYC - 1);

    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   op_addr_q;
    logic [7:0]          op_data_q;
    logic [ADDR_W-1:0]   walk_q;
    logic [SECT_W-1:0]   sect_q;
    logic                tmr_load;
    logic [CW-1:0]       tmr_val;
    logic                tmr_done;
    logic                prog_mode;
    logic [BYTE_W-1:0]   status;
    logic                accept;

    assign accept = (state_q == ST_IDLE) && start && (op_e'(start_op) != OP_NONE);

    // state register and operand latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_addr_q <= '0;
            op_data_q <= '0;
            walk_q    <= '0;
            sect_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_addr_q <= start_addr;
                op_data_q <= start_data;
                walk_q    <= '0;
                sect_q    <= '0;
            end
            if (state_q == ST_PRE_VERIFY && arr_rdata == 8'h00 && walk_q != '1)
                walk_q <= walk_q + 1'b1;
            if (state_q == ST_CHIP_PULSE)
                sect_q <= sect_q + 1'b1;
        end
    end

    // next state and timer load
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = PROG_LD;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op_e'(start_op))
                        OP_PROG: begin state_d = ST_PROG_WAIT; tmr_load = 1'b1; tmr_val = PROG_LD; end
                        OP_SECT: begin state_d = ST_SECT_WAIT; tmr_load = 1'b1; tmr_val = SECT_LD; end
                        OP_CHIP: state_d = ST_PRE_WRITE;
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PROG_WAIT:  if (tmr_done) state_d = ST_PROG_WRITE;
            ST_PROG_WRITE: state_d = ST_IDLE;
            ST_SECT_WAIT:  if (tmr_done) state_d = ST_SECT_PULSE;
            ST_SECT_PULSE: state_d = ST_IDLE;
            ST_PRE_WRITE:  state_d = ST_PRE_VERIFY;
            ST_PRE_VERIFY: begin
                if (arr_rdata != 8'h00 || walk_q != '1) begin
                    state_d = ST_PRE_WRITE;
                end else begin
                    state_d  = ST_CHIP_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CHIP_LD;
                end
            end
            ST_CHIP_WAIT:  if (tmr_done) state_d = ST_CHIP_PULSE;
            ST_CHIP_PULSE: begin
                if (sect_q == '1) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d  = ST_CHIP_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CHIP_LD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        prog_mode  = (state_q == ST_PROG_WAIT) || (state_q == ST_PROG_WRITE);
        arr_we     = (state_q == ST_PROG_WRITE) || (state_q == ST_PRE_WRITE);
        arr_erase  = (state_q == ST_SECT_PULSE) || (state_q == ST_CHIP_PULSE);
        arr_sector = (state_q == ST_CHIP_PULSE) ? sect_q : op_addr_q[ADDR_W-1 -: SECT_W];
        unique case (state_q)
            ST_IDLE:                     arr_addr = host_addr;
            ST_PRE_WRITE, ST_PRE_VERIFY: arr_addr = walk_q;
            default:                     arr_addr = op_addr_q;
        endcase
        arr_wdata  = (state_q == ST_PROG_WRITE) ? (arr_rdata & op_data_q) : 8'h00;
        host_rdata = busy ? status : arr_rdata;
    end

    op_timer #(.CW(CW)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    status_gen stat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .rd        (host_rd),
        .prog_mode (prog_mode),
        .prog_bit7 (op_data_q[7]),
        .status    (status)
    );

    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && start_op != 2'b00) |=> busy);
    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(op_addr_q) && $stable(op_data_q)));
    assert_status_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (host_rdata[5:0] == 6'b0));
    assert_erase_bit7_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prog_mode) |-> (host_rdata[7] == 1'b0));
    assert_clear_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_WRITE) |-> ((arr_wdata & ~arr_rdata) == 8'h00));
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_we && arr_erase));
endmodule

// File: tb/flash_op_seq_tb_top.sv
`timescale 1ns/1ps
module flash_op_seq_tb_top;
    localparam int AW = 6;
    localparam int SW = 2;
    localparam int PC = 4;
    localparam int SC = 6;
    localparam int CC = 5;
    localparam int NB = 1 << AW;
    localparam int NS = 1 << SW;
    localparam int SB = NB / NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    start_op = 2'b00;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    start_data = 8'h00;
    logic          host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_rdata;
    logic          busy;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_rdata;
    logic          arr_we;
    logic [7:0]    arr_wdata;
    logic          arr_erase;
    logic [SW-1:0] arr_sector;

    always #4 clk = ~clk;

    flash_op_seq #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PC), .SERASE_CYC(SC), .CHIP_SECT_CYC(CC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
        .start_addr(start_addr), .start_data(start_data), .host_rd(host_rd),
        .host_addr(host_addr), .host_rdata(host_rdata), .busy(busy),
        .arr_addr(arr_addr), .arr_rdata(arr_rdata), .arr_we(arr_we),
        .arr_wdata(arr_wdata), .arr_erase(arr_erase), .arr_sector(arr_sector)
    );

    // array model
    logic [7:0] mem [NB];
    logic       drop5 = 1'b0;
    assign arr_rdata = mem[arr_addr];
    initial for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
    always @(posedge clk) begin
        if (arr_we) begin
            if (drop5 && arr_addr == AW'(5)) drop5 <= 1'b0;
            else mem[arr_addr] <= arr_wdata;
        end
        if (arr_erase)
            for (int i = 0; i < SB; i++) mem[int'(arr_sector) * SB + i] <= 8'hFF;
    end

    // reference model
    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] exp_mem [NB];
    int         m_left = 0;
    int         m_kind = 0;
    logic       m_b7 = 1'b0;
    logic       m_tog = 1'b0;
    logic [7:0] m_wval = 8'h00;
    int         m_sect = 0;
    int         pp_next = 0;
    int         pp_writes = 0;
    int         wr5 = 0;
    int         se_next = 0;
    int         n_pulses = 0;
    bit         finished = 0;

    initial for (int i = 0; i < NB; i++) exp_mem[i] = 8'hFF;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic clk_step();
        logic [7:0] er;
        @(negedge clk);
        check(busy == (m_left > 0), "R2/R3 busy", busy, (m_left > 0));
        er = (m_left > 0) ? {m_b7, m_tog, 6'b0} : exp_mem[host_addr];
        check(host_rdata == er, "R4/R5/R6/R11 host_rdata", host_rdata, er);
        if (m_left == 0) check(arr_addr == host_addr, "R11 arr_addr", arr_addr, host_addr);
        if (arr_we) begin
            if (m_kind == 1) begin
                check(arr_wdata == m_wval, "R10 write value", arr_wdata, m_wval);
                check(m_left == 1, "R3 write in last cycle", m_left, 1);
            end else if (m_kind == 3) begin
                pp_writes++;
                if (arr_addr == AW'(5)) wr5++;
                check(arr_wdata == 8'h00, "R8 zero write", arr_wdata, 0);
                check(int'(arr_addr) == pp_next || int'(arr_addr) == pp_next - 1,
                      "R8 ascending walk", arr_addr, pp_next);
                if (int'(arr_addr) == pp_next) pp_next++;
            end
        end
        if (arr_erase) begin
            n_pulses++;
            if (m_kind == 2) check(int'(arr_sector) == m_sect, "R7 sector", arr_sector, m_sect);
            else if (m_kind == 3) begin
                check(int'(arr_sector) == se_next, "R9 sector order", arr_sector, se_next);
                check(pp_next == NB, "R9 after walk", pp_next, NB);
                se_next++;
            end
        end
        if (rst_n) begin
            if (m_left > 0) begin
                if (host_rd) m_tog = ~m_tog;
                m_left--;
            end else if (start && start_op != 2'b00) begin
                m_kind = int'(start_op);
                if (start_op == 2'b01) begin
                    m_left = PC + 1;
                    m_b7 = ~start_data[7];
                    m_wval = exp_mem[start_addr] & start_data;
                    exp_mem[start_addr] = m_wval;
                end else if (start_op == 2'b10) begin
                    m_left = SC + 1;
                    m_b7 = 1'b0;
                    m_sect = int'(start_addr) / SB;
                    for (int i = 0; i < SB; i++) exp_mem[m_sect * SB + i] = 8'hFF;
                end else begin
                    m_left = 2 * NB + (drop5 ? 2 : 0) + NS * (CC + 1);
                    m_b7 = 1'b0;
                    pp_next = 0; pp_writes = 0; wr5 = 0; se_next = 0;
                    for (int i = 0; i < NB; i++) exp_mem[i] = 8'hFF;
                end
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic run_op(input logic [1:0] op, input int addr, input logic [7:0] d, input int rd_every);
        int k;
        start = 1'b1; start_op = op; start_addr = AW'(addr); start_data = d;
        clk_step();
        start = 1'b0;
        k = 0;
        while (busy) begin
            host_rd = (rd_every > 0) && (k % rd_every == 0);
            host_addr = AW'(k);
            if (k == 2) begin
                start = 1'b1; start_op = 2'b10; start_addr = AW'(40);   // R2 ignored while busy
            end else start = 1'b0;
            clk_step();
            k++;
        end
        start = 1'b0; host_rd = 1'b0;
    endtask

    initial begin
        #5000000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) clk_step();
        rst_n = 1'b1;
        clk_step();
        // R1 reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(arr_we == 1'b0 && arr_erase == 1'b0, "R1 strobes", {arr_we, arr_erase}, 0);
        // R11 idle reads
        for (int a = 0; a < 4; a++) begin host_addr = AW'(a); clk_step(); end
        // R2 code 00 has no effect
        start = 1'b1; start_op = 2'b00; start_addr = AW'(3);
        clk_step(); start = 1'b0; clk_step();
        check(busy == 1'b0, "R2 op 00 ignored", busy, 0);
        // R3/R5/R6 program, reads every cycle
        run_op(2'b01, 3, 8'h5A, 1);
        host_addr = AW'(3); clk_step();
        check(host_rdata == 8'h5A, "R3 programmed byte", host_rdata, 8'h5A);
        // R10 clear-only
        run_op(2'b01, 3, 8'hF0, 2);
        host_addr = AW'(3); clk_step();
        check(host_rdata == 8'h50, "R10 and-merge", host_rdata, 8'h50);
        run_op(2'b01, 20, 8'h80, 3);
        host_addr = AW'(40); clk_step();
        check(host_rdata == 8'hFF, "R2 ignored erase left byte", host_rdata, 8'hFF);
        // R7 sector erase of sector 0
        run_op(2'b10, 7, 8'h00, 1);
        host_addr = AW'(3); clk_step();
        check(host_rdata == 8'hFF, "R7 erased byte", host_rdata, 8'hFF);
        host_addr = AW'(20); clk_step();
        check(host_rdata == 8'h80, "R7 other sector kept", host_rdata, 8'h80);
        // R8/R9 chip erase with one dropped write
        run_op(2'b01, 33, 8'h12, 0);
        drop5 = 1'b1;
        n_pulses = 0;
        run_op(2'b11, 0, 8'h00, 2);
        check(wr5 == 2, "R8 rewrite after failed verify", wr5, 2);
        check(pp_writes == NB + 1, "R8 write count", pp_writes, NB + 1);
        check(n_pulses == NS, "R9 pulse count", n_pulses, NS);
        for (int a = 0; a < NB; a += 9) begin host_addr = AW'(a); clk_step(); end
        host_addr = AW'(33); clk_step();
        check(host_rdata == 8'hFF, "R9 chip erased", host_rdata, 8'hFF);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule